// File: doc/BRIEF.md
# Preset-and-combine ALU

This block is a purely combinational arithmetic logic unit for two `WIDTH`-bit two's-complement operands. It has no opcode decoder. Six independent control bits each apply one simple transform at a fixed point in the datapath. Each operand can be forced to zero and then inverted bit by bit. The core step either adds the two prepared operands or ANDs them. The core result can then be inverted. Two flags report whether the result is all zeros and whether its sign bit is set.

Chaining these transforms gives eighteen useful functions: constants, copies of each operand, bitwise NOT, negations, increments, decrements, sum, both differences, AND and OR. For example, leaving x untouched and turning y into all ones (zero, then invert) before the add gives x-1. A surrounding datapath drives the six bits straight from an instruction field and reads the result and flags in the same cycle.

Top module: `preset_alu`

## Requirements
- R1: When `zero_x_i` is 1 the x operand entering the core is all zeros before optional inversion; otherwise it is `x_i`.
- R2: When `inv_x_i` is 1 the (possibly zeroed) x operand is inverted bit by bit. Zeroing always comes first, so `zero_x_i`=1 with `inv_x_i`=1 yields all ones.
- R3: `zero_y_i` and `inv_y_i` act on `y_i` in the same way and in the same order as R1 and R2 act on x.
- R4: When `add_sel_i` is 1 the core result is the sum of the prepared operands modulo 2^WIDTH. The carry ripples from bit 0 upward, and the carry out of the top bit is dropped.
- R5: When `add_sel_i` is 0 the core result is the bitwise AND of the prepared operands.
- R6: When `inv_out_i` is 1 `out_o` is the bitwise inverse of the core result; when it is 0 `out_o` equals the core result.
- R7: `zero_o` is 1 exactly when every bit of `out_o` is 0.
- R8: `neg_o` equals bit WIDTH-1 of `out_o`.
- R9: With control word c[5:0] = {zero_x, inv_x, zero_y, inv_y, add_sel, inv_out}, the words give these functions:
  - 101010 → 0, 111111 → 1, 111010 → -1
  - 001100 → x, 110000 → y, 001101 → ~x, 110001 → ~y
  - 001111 → -x, 110011 → -y
  - 011111 → x+1, 110111 → y+1, 001110 → x-1, 110010 → y-1
  - 000010 → x+y, 010011 → x-y, 000111 → y-x
  - 000000 → x&y, 010101 → x|y
- R10: The unit holds no state; outputs follow the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand |
| zero_x_i | input | 1 | Force x operand to zero |
| inv_x_i | input | 1 | Invert x operand after zeroing |
| zero_y_i | input | 1 | Force y operand to zero |
| inv_y_i | input | 1 | Invert y operand after zeroing |
| add_sel_i | input | 1 | 1 selects add, 0 selects AND |
| inv_out_i | input | 1 | Invert the core result |
| out_o | output | WIDTH | Result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Sign bit of result |

## Verification
The bench builds the unit at its default width of 16. At that width the corner operands 0, 1, -1, 0x8000 and 0x7FFF are exact, so the checks reach:
- carry wrap-around at the top bit;
- the sign flip of negating the most negative value;
- long carry ripples such as -1 + 1.

Each of the eighteen control words is compared against a function written directly from its name, over these corners and random pairs. OR is also checked separately through its De Morgan form.

// File: rtl/preset_alu_pkg.sv
package preset_alu_pkg;
  typedef enum logic {
    OP_AND = 1'b0,
    OP_ADD = 1'b1
  } core_op_e;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] d_i,
  input  logic             zero_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] d_o
);
  logic [WIDTH-1:0] zeroed;

  assign zeroed = zero_i ? '0 : d_i;
  assign d_o    = inv_i ? ~zeroed : zeroed;

  always_comb begin
    if (zero_i) begin
      assert_prep_const_R1: assert (d_o == {WIDTH{inv_i}})
        else $error("prep constant mismatch");
    end
    if (!zero_i && inv_i) begin
      assert_prep_inv_R2: assert ((d_o & d_i) == '0 && (d_o | d_i) == '1)
        else $error("prep inversion mismatch");
    end
  end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] cin;

  assign cin[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic hx;
    assign hx       = a_i[i] ^ b_i[i];
    assign sum_o[i] = hx ^ cin[i];
    if (i < WIDTH - 1) begin : g_carry
      // MSB carry is not built: wrap modulo 2^WIDTH
      assign cin[i+1] = (a_i[i] & b_i[i]) | (hx & cin[i]);
    end
  end

  always_comb begin
    assert_add_lsb_R4: assert (sum_o[0] == (a_i[0] ^ b_i[0]))
      else $error("adder lsb mismatch");
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import preset_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  core_op_e         op_i,
  output logic [WIDTH-1:0] r_o
);
  logic [WIDTH-1:0] sum;

  alu_ripple_adder #(.WIDTH(WIDTH)) u_add (
    .a_i  (a_i),
    .b_i  (b_i),
    .sum_o(sum)
  );

  assign r_o = (op_i == OP_ADD) ? sum : (a_i & b_i);

  always_comb begin
    if (op_i == OP_AND) begin
      assert_core_and_R5: assert ((r_o & ~a_i) == '0 && (r_o & ~b_i) == '0)
        else $error("and result outside operands");
    end
  end
endmodule

// File: rtl/preset_alu.sv
module preset_alu
  import preset_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             zero_x_i,
  input  logic             inv_x_i,
  input  logic             zero_y_i,
  input  logic             inv_y_i,
  input  logic             add_sel_i,
  input  logic             inv_out_i,
  output logic [WIDTH-1:0] out_o,
  output logic             zero_o,
  output logic             neg_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x_prep, y_prep, core_r;
  core_op_e         op;

  assign op = add_sel_i ? OP_ADD : OP_AND;

  alu_operand_prep #(.WIDTH(WIDTH)) u_prep_x (
    .d_i   (x_i),
    .zero_i(zero_x_i),
    .inv_i (inv_x_i),
    .d_o   (x_prep)
  );

  alu_operand_prep #(.WIDTH(WIDTH)) u_prep_y (
    .d_i   (y_i),
    .zero_i(zero_y_i),
    .inv_i (inv_y_i),
    .d_o   (y_prep)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .a_i(x_prep),
    .b_i(y_prep),
    .op_i(op),
    .r_o(core_r)
  );

  assign out_o  = inv_out_i ? ~core_r : core_r;
  assign zero_o = ~|out_o;
  assign neg_o  = out_o[MSB];

  always_comb begin
    if (!inv_out_i) begin
      assert_out_pass_R6: assert (out_o == core_r)
        else $error("output pass mismatch");
    end
    assert_flags_excl_R7: assert (!(zero_o && neg_o))
      else $error("zero and negative together");
    if (neg_o) begin
      assert_neg_nonzero_R8: assert (out_o != '0)
        else $error("negative with zero result");
    end
  end
endmodule

// File: tb/preset_alu_tb.sv
module preset_alu_tb;
  localparam int WIDTH = 16;
  localparam int NFUNC = 18;
  localparam int NCORNER = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [WIDTH-1:0] x, y, out;
  logic zx, ix, zy, iy, ad, io, zf, nf;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  preset_alu #(.WIDTH(WIDTH)) u_dut (
    .x_i(x), .y_i(y),
    .zero_x_i(zx), .inv_x_i(ix), .zero_y_i(zy), .inv_y_i(iy),
    .add_sel_i(ad), .inv_out_i(io),
    .out_o(out), .zero_o(zf), .neg_o(nf)
  );

  function automatic logic [5:0] ctrl_of(int k);
    case (k)
      0:  return 6'b101010; 1:  return 6'b111111; 2:  return 6'b111010;
      3:  return 6'b001100; 4:  return 6'b110000; 5:  return 6'b001101;
      6:  return 6'b110001; 7:  return 6'b001111; 8:  return 6'b110011;
      9:  return 6'b011111; 10: return 6'b110111; 11: return 6'b001110;
      12: return 6'b110010; 13: return 6'b000010; 14: return 6'b010011;
      15: return 6'b000111; 16: return 6'b000000; default: return 6'b010101;
    endcase
  endfunction

  function automatic logic [WIDTH-1:0] ref_of(int k, logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    case (k)
      0:  return '0;          1:  return 1;           2:  return '1;
      3:  return a;           4:  return b;           5:  return ~a;
      6:  return ~b;          7:  return -a;          8:  return -b;
      9:  return a + 1;       10: return b + 1;       11: return a - 1;
      12: return b - 1;       13: return a + b;       14: return a - b;
      15: return b - a;       16: return a & b;       default: return a | b;
    endcase
  endfunction

  function automatic logic [WIDTH-1:0] corner(int i);
    case (i)
      0: return '0;
      1: return 1;
      2: return '1;
      3: return {1'b1, {(WIDTH-1){1'b0}}};
      default: return {1'b0, {(WIDTH-1){1'b1}}};
    endcase
  endfunction

  task automatic apply(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, logic [5:0] c);
    @(posedge clk);
    #1;
    x = a; y = b;
    {zx, ix, zy, iy, ad, io} = c;
    @(negedge clk);
  endtask

  task automatic check(string req, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_flags(string req);
    check({req, "_R7"}, WIDTH'(zf), WIDTH'(out == '0));
    check({req, "_R8"}, WIDTH'(nf), WIDTH'(out[WIDTH-1]));
  endtask

  // R10: no clock edge between input change and result
  task automatic test_idle_state();
    apply('0, '0, 6'b000000);
    check("R10 idle", out, '0);
    check("R7 idle zero", WIDTH'(zf), 1);
    check("R8 idle neg", WIDTH'(nf), 0);
  endtask

  // R1 R2 R3 preparation order, observed through AND / add paths
  task automatic test_prep();
    apply(16'h1234, '1, 6'b100000);
    check("R1 zero x", out, '0);
    apply(16'h1234, 16'h0F0F, 6'b110000);
    check("R2 zero then invert x", out, 16'h0F0F);
    apply(16'h00FF, '1, 6'b010000);
    check("R2 invert x", out, 16'hFF00);
    apply('1, 16'h5A5A, 6'b001000);
    check("R3 zero y", out, '0);
    apply(16'hF0F0, 16'h1234, 6'b001100);
    check("R3 zero then invert y", out, 16'hF0F0);
    apply('1, 16'h00FF, 6'b000100);
    check("R3 invert y", out, 16'hFF00);
  endtask

  // R4 addition with wrap, R5 AND, R6 output inversion
  task automatic test_core();
    apply('1, 16'h0001, 6'b000010);
    check("R4 wrap -1+1", out, '0);
    check_flags("wrap");
    apply(16'h7FFF, 16'h0001, 6'b000010);
    check("R4 carry into msb", out, 16'h8000);
    check_flags("msb");
    apply(16'h8000, 16'h8000, 6'b000010);
    check("R4 top carry dropped", out, '0);
    apply(16'hCAFE, 16'h0FF0, 6'b000000);
    check("R5 and", out, 16'h0AF0);
    apply(16'hCAFE, 16'h0FF0, 6'b000001);
    check("R6 inverted and", out, 16'hF50F);
    apply(16'h1111, 16'h2222, 6'b000011);
    check("R6 inverted sum", out, ~16'h3333);
  endtask

  // R9: every named word over corners and random operands
  task automatic test_named();
    for (int k = 0; k < NFUNC; k++) begin
      for (int i = 0; i < NCORNER; i++) begin
        for (int j = 0; j < NCORNER; j++) begin
          apply(corner(i), corner(j), ctrl_of(k));
          check($sformatf("R9 word %0d corner", k), out, ref_of(k, corner(i), corner(j)));
          check_flags("R9c");
        end
      end
      for (int r = 0; r < 20; r++) begin
        logic [WIDTH-1:0] a, b;
        a = WIDTH'($urandom);
        b = WIDTH'($urandom);
        apply(a, b, ctrl_of(k));
        check($sformatf("R9 word %0d random", k), out, ref_of(k, a, b));
      end
    end
  endtask

  // R9: OR through inverted inputs, AND, inverted output
  task automatic test_or();
    for (int r = 0; r < 30; r++) begin
      logic [WIDTH-1:0] a, b;
      a = WIDTH'($urandom);
      b = WIDTH'($urandom);
      apply(a, b, 6'b010101);
      check("R9 or via demorgan", out, a | b);
    end
  endtask

  initial begin
    x = '0; y = '0;
    {zx, ix, zy, iy, ad, io} = '0;
    test_idle_state();
    test_prep();
    test_core();
    test_named();
    test_or();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule